// File: doc/BRIEF.md
# Self-Recovering Twisted-Ring Counter

This block is a parameterised twisted-ring (Johnson) shift counter with its own fault watchdog. It has `STAGES` flip-flops and uses only 2×`STAGES` of their 2^`STAGES` codes. When it is healthy, it walks through those codes with a period of 2×`STAGES` clocks. Once per period the register holds all ones. A detector sees that state and emits an active-low sync strobe. The same detection retriggers a one-shot timer that counts clocks.

A flip-flop upset can move the register into an unused code. Without help, the register would then circulate among unused codes forever. Such a code never reaches the all-ones state, so the timer is not retriggered and it expires. While the timer is expired, the feed into the first stage is forced to one. After at most `STAGES` shifts the register is all ones, the timer reloads, and the normal walk resumes. An upset-load input places an arbitrary code in the register so that this recovery can be exercised.

Top module: `johnson_watchdog`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register is cleared to zero, `sync_n` goes to 1 and `fault` goes to 0. Reset takes priority over every other input.
- R2: While `fault` is 0 and `upset_en` is 0, each clock shifts `stage_q` one position toward its MSB, and bit 0 takes the inverse of the old MSB. From zero, the register returns to zero after exactly 2×`STAGES` clocks and is all ones after `STAGES` clocks.
- R3: `sync_n` is 0 for one clock following each clock edge at which `stage_q` was all ones. It is 1 otherwise.
- R4: The timer loads `TIMEOUT` on reset and on every edge at which `stage_q` is all ones. On other edges it counts down to zero and holds there. `fault` is 1 exactly while the count is zero, so a healthy counter never shows `fault`.
- R5: While `fault` is 1 and `upset_en` is 0, each clock shifts the register toward its MSB and bit 0 takes the value 1.
- R6: If the register becomes all ones while `fault` is 1, then on the next edge `fault` returns to 0 and the register stays all ones. On the edge after that, the register becomes all ones with bit 0 cleared, and the normal walk continues.
- R7: The register is all ones no more than `TIMEOUT`+`STAGES` clock edges after the later of the last all-ones edge and the last upset load.
- R8: When `upset_en` is 1 and `rst` is 0, the next edge loads `upset_val` into the register in place of the shift.
- R9: Loading an unused code, one not reachable in the 2×`STAGES` walk (for example 8'b01010101), makes `fault` rise before recovery. Loading a code on the walk (for example 8'b00001111) raises no `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upset_en | input | 1 | Load `upset_val` into the register on the next edge |
| upset_val | input | STAGES | Code to load when `upset_en` is high |
| stage_q | output | STAGES | Parallel stage outputs, bit 0 is the first stage |
| sync_n | output | 1 | Active-low strobe, one clock after an all-ones state |
| fault | output | 1 | High while the watchdog timer has expired |

## Verification
The recovery-time property assumes that the `upset_en` pulses are single events and not a stream. Each load restarts the window it measures, so a continuous stream of loads would keep the register away from all ones without breaking the bound. The walk property assumes that `upset_en` is low on the cycle it checks. The stimulus raises `upset_en` for one clock per scenario and waits for recovery to finish before the next load, except in the scenario that applies reset in the middle of a fault. A cycle-by-cycle reference model, built from the requirements, follows every clock of every scenario.

// File: rtl/jcw_pkg.sv
package jcw_pkg;
  typedef enum logic {
    FEED_TWIST = 1'b0,
    FEED_FORCE = 1'b1
  } feed_mode_e;
endpackage

// File: rtl/jcw_ring.sv
module jcw_ring
  import jcw_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [STAGES-1:0] load_val,
  input  feed_mode_e        feed_mode,
  output logic [STAGES-1:0] q
);
  localparam int MSB = STAGES - 1;

  logic feed_bit;
  assign feed_bit = (feed_mode == FEED_FORCE) ? 1'b1 : ~q[MSB];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic d;
    if (s == 0) begin : g_first
      assign d = feed_bit;
    end else begin : g_rest
      assign d = q[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst)          q[s] <= 1'b0;
      else if (load_en) q[s] <= load_val[s];
      else              q[s] <= d;
    end
  end

  // R5: an expired watchdog pushes a one into the first stage
  p_force_one_r5: assert property (@(posedge clk) disable iff (rst)
    (feed_mode == FEED_FORCE && !load_en) |=> q[0]);

  // R8: an upset load lands unchanged
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    load_en |=> q == $past(load_val));
endmodule

// File: rtl/jcw_sync_det.sv
module jcw_sync_det #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] q,
  output logic              all_ones,
  output logic              sync_n
);
  assign all_ones = &q;

  always_ff @(posedge clk) begin
    if (rst) sync_n <= 1'b1;
    else     sync_n <= ~all_ones;
  end

  // R3: strobe follows the all-ones state by one clock
  p_sync_after_r3: assert property (@(posedge clk) disable iff (rst)
    all_ones |=> !sync_n);
  p_sync_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !all_ones |=> sync_n);
endmodule

// File: rtl/jcw_oneshot.sv
module jcw_oneshot #(
  parameter int TIMEOUT = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic alive
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= LOAD;
    else if (trig)          cnt <= LOAD;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign alive = (cnt != '0);

  // R4: every trigger restarts the full timeout
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    trig |=> cnt == LOAD);
  // R4: without a trigger an expired timer stays expired
  p_hold_expired_r4: assert property (@(posedge clk) disable iff (rst)
    (!alive && !trig) |=> !alive);
endmodule

// File: rtl/johnson_watchdog.sv
module johnson_watchdog
  import jcw_pkg::*;
#(
  parameter int STAGES  = 8,
  parameter int TIMEOUT = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upset_en,
  input  logic [STAGES-1:0] upset_val,
  output logic [STAGES-1:0] stage_q,
  output logic              sync_n,
  output logic              fault
);
  localparam int BOUND = TIMEOUT + STAGES;
  localparam int GW    = $clog2(BOUND + 2);

  initial begin
    assert (TIMEOUT > 2 * STAGES && TIMEOUT <= 4 * STAGES)
      else $error("TIMEOUT must lie in (2*STAGES, 4*STAGES]");
  end

  logic       all_ones;
  logic       alive;
  feed_mode_e feed;

  assign feed  = alive ? FEED_TWIST : FEED_FORCE;
  assign fault = ~alive;

  jcw_ring #(.STAGES(STAGES)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .load_en  (upset_en),
    .load_val (upset_val),
    .feed_mode(feed),
    .q        (stage_q)
  );

  jcw_sync_det #(.STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .q       (stage_q),
    .all_ones(all_ones),
    .sync_n  (sync_n)
  );

  jcw_oneshot #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .trig (all_ones),
    .alive(alive)
  );

  // Gap monitor for the recovery bound
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst || all_ones || upset_en) gap <= '0;
    else if (gap != GW'(BOUND + 1))  gap <= gap + 1'b1;
  end

  // R7: all ones is reached within TIMEOUT+STAGES edges
  p_recover_bound_r7: assert property (@(posedge clk) disable iff (rst)
    gap <= GW'(BOUND));

  // R2: healthy stepping is a twisted shift
  p_twist_step_r2: assert property (@(posedge clk) disable iff (rst)
    (alive && !upset_en) |=>
      stage_q == {$past(stage_q[STAGES-2:0]), ~$past(stage_q[STAGES-1])});

  // R6: reaching all ones while expired clears the fault and holds the ones
  p_fault_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (fault && all_ones && !upset_en) |=> (!fault && (&stage_q)));
endmodule

// File: tb/tb_johnson_watchdog.sv
`timescale 1ns/1ps
module tb_johnson_watchdog;
  localparam int N  = 8;
  localparam int TO = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         upset_en = 1'b0;
  logic [N-1:0] upset_val = '0;
  logic [N-1:0] stage_q;
  logic         sync_n;
  logic         fault;

  always #2 clk = ~clk;

  johnson_watchdog #(.STAGES(N), .TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .upset_en(upset_en), .upset_val(upset_val),
    .stage_q(stage_q), .sync_n(sync_n), .fault(fault)
  );

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [N-1:0] m_q;
  int           m_cnt;
  logic         m_sync;
  bit           m_valid = 1'b0;

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [N-1:0] nq;
    int           ncnt;
    logic         nsync;
    logic         allon;
    logic         alive;
    logic         sin;
    bit           was_fault;
    allon = &m_q;
    alive = (m_cnt != 0);
    was_fault = !alive;
    if (rst) begin
      nq = '0; ncnt = TO; nsync = 1'b1;
    end else begin
      nsync = ~allon;
      sin   = ~(m_q[N-1] & alive);
      nq    = upset_en ? upset_val : {m_q[N-2:0], sin};
      ncnt  = allon ? TO : (alive ? m_cnt - 1 : 0);
    end
    if (rst) m_valid = 1'b1;
    @(posedge clk);
    #1;
    m_q = nq; m_cnt = ncnt; m_sync = nsync;
    if (m_valid) begin
      cmp((was_fault && !rst) ? "R5 stage_q" : "R2 stage_q", 64'(stage_q), 64'(m_q));
      cmp("R3 sync_n", 64'(sync_n), 64'(m_sync));
      cmp("R4 fault", 64'(fault), 64'(m_cnt == 0));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    cmp("R1 stage_q", 64'(stage_q), 64'd0);
    cmp("R1 sync_n", 64'(sync_n), 64'd1);
    cmp("R1 fault", 64'(fault), 64'd0);
  endtask

  task automatic t_legal_walk();
    bit any_fault = 1'b0;
    t_reset();
    for (int i = 0; i < N; i++) tick();
    cmp("R2 all ones after N", 64'(stage_q), 64'({N{1'b1}}));
    tick();
    cmp("R3 strobe low", 64'(sync_n), 64'd0);
    cmp("R2 first zero", 64'(stage_q), 64'({{(N-1){1'b1}}, 1'b0}));
    for (int i = N + 1; i < 2 * N; i++) tick();
    cmp("R2 period", 64'(stage_q), 64'd0);
    for (int i = 0; i < 6 * N; i++) begin
      tick();
      if (fault) any_fault = 1'b1;
    end
    cmp("R4 no fault when healthy", 64'(any_fault), 64'd0);
  endtask

  task automatic t_upset(input logic [N-1:0] val);
    int  edges = 0;
    bit  saw_fault = 1'b0;
    upset_en = 1'b1; upset_val = val;
    tick();
    upset_en = 1'b0;
    cmp("R8 loaded", 64'(stage_q), 64'(val));
    while (!(&stage_q) && edges <= TO + N + 4) begin
      tick();
      edges++;
      if (fault) saw_fault = 1'b1;
    end
    cmp("R7 within bound", 64'(edges <= TO + N), 64'd1);
    cmp("R9 fault raised", 64'(saw_fault), 64'd1);
    tick();
    cmp("R6 fault cleared", 64'(fault), 64'd0);
    cmp("R6 ones held", 64'(stage_q), 64'({N{1'b1}}));
    tick();
    cmp("R6 walk resumes", 64'(stage_q), 64'({{(N-1){1'b1}}, 1'b0}));
    for (int i = 0; i < 2 * N; i++) tick();
  endtask

  task automatic t_upset_legal();
    bit any_fault = 1'b0;
    upset_en = 1'b1; upset_val = 8'b00001111;
    tick();
    upset_en = 1'b0;
    cmp("R8 legal load", 64'(stage_q), 64'h0F);
    for (int i = 0; i < 4 * N; i++) begin
      tick();
      if (fault) any_fault = 1'b1;
    end
    cmp("R9 legal code no fault", 64'(any_fault), 64'd0);
  endtask

  task automatic t_reset_in_fault();
    upset_val = 8'b00100100; upset_en = 1'b1;
    tick();
    upset_en = 1'b0;
    while (!fault && m_cnt > 0) tick();
    cmp("R4 fault before reset", 64'(fault), 64'd1);
    rst = 1'b1; upset_en = 1'b1; upset_val = 8'hAA;
    tick();
    rst = 1'b0; upset_en = 1'b0;
    cmp("R1 reset beats fault", 64'(fault), 64'd0);
    cmp("R1 reset beats load", 64'(stage_q), 64'd0);
    cmp("R1 sync idle", 64'(sync_n), 64'd1);
    for (int i = 0; i < 3 * N; i++) tick();
  endtask

  initial begin
    t_legal_walk();
    t_upset(8'b01010101);
    t_upset(8'b00100000);
    t_upset(8'b11011111);
    t_upset(8'b10110010);
    t_upset_legal();
    t_reset_in_fault();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule